// File: doc/BRIEF.md
# Serializer Load Pulse Generator

This block produces the load strobe for a ten-to-one parallel-to-serial converter. It runs entirely on the fast (10X) clock. It watches a sync strobe that comes from the slow parallel-data domain and has already been sampled into the fast domain. Each rising edge of that strobe starts one load pulse, which leaves the block a programmable number of fast-clock flop stages later. A 4-bit phase select sets that delay, which lets the integrator line the load moment up with the parallel data at the serializer input.

The select is sampled at the same fast-clock edge that detects the sync rise, and the pulse is written straight into a shift line at the slot for that delay. Every pulse in flight therefore keeps the delay it was launched with. Changing the select between sync edges cannot duplicate, drop or move a pulse. Delays longer than one slow-clock period are allowed, and they push the load point into the following parallel word. An out-of-range select raises a flag and falls back to the default delay.

Top module: `serlp_load_pulse_gen`

## Requirements
- R1: While reset is low, `load_pulse_o` and `sel_err_o` are 0. A reset that arrives while a pulse is in flight discards that pulse, so no load pulse appears after reset is released.
- R2: A legal select code N, with a binary value from 4 (4'b0100) to 13 (4'b1101), gives N+1 flop stages of delay. If the sync rise is sampled at clock edge E0, then `load_pulse_o` is high during the cycle that follows edge E0+N.
- R3: Each sync rising edge produces exactly one load pulse that is one fast-clock cycle wide. Holding `sync_i` high for several cycles produces no further pulses.
- R4: The codes 0 to 3, 14 and 15 are illegal. A sync rise that samples one of them uses delay 6 (the default), and `sel_err_o` is 1 from the following cycle onward.
- R5: `sel_err_o` changes only at a sync rising edge. It reflects the select code captured at the most recent rise and holds that value between rises, whatever `phase_sel_i` does in the meantime.
- R6: The select is captured at the sync rise. A change to `phase_sel_i` while a pulse is in flight does not alter when that pulse appears.
- R7: A new sync rise can arrive while an earlier long-delay pulse (delay 10 or more) is still in flight. When that happens, each pulse appears at the position set by its own captured select. For example, a delay-13 pulse and a delay-5 pulse launched 10 cycles later both appear, 2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast (10X) serializer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Parallel-word sync strobe, already in the fast domain |
| phase_sel_i | input | 4 | Load phase select code |
| load_pulse_o | output | 1 | One-cycle serializer load strobe |
| sel_err_o | output | 1 | Captured select code was illegal |

## Verification
The bench builds the block with its default parameters: a 4-bit select, a legal window of 4 to 13, and a default of 6. This makes all sixteen select encodings reachable, so the table sweeps every legal tap and every illegal fallback against a delay count that the bench derives itself. The 14-stage line that results also makes room for the longest delay to overlap a following sync period. The directed tests exercise exactly this overlap, together with select changes while a pulse is in flight and a reset that lands mid-flight.

// File: rtl/serlp_pkg.sv
package serlp_pkg;

    // True when code lies inside [lo, hi].
    function automatic logic code_in_range(input int unsigned code,
                                           input int unsigned lo,
                                           input int unsigned hi);
        return (code >= lo) && (code <= hi);
    endfunction

endpackage

// File: rtl/serlp_edge_detect.sv
module serlp_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic rise_o
);

    typedef struct packed {
        logic prev;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.prev = sync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rise_o = sync_i & ~state_q.prev;

endmodule

// File: rtl/serlp_phase_decode.sv
module serlp_phase_decode #(
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned MIN_PHASE = 4,
    parameter int unsigned MAX_PHASE = 13,
    parameter int unsigned DEF_PHASE = 6,
    parameter int unsigned TAP_W     = 4
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             illegal_o
);

    import serlp_pkg::*;

    logic legal;

    always_comb begin
        legal     = code_in_range(32'(sel_i), MIN_PHASE, MAX_PHASE);
        illegal_o = ~legal;
        tap_o     = legal ? TAP_W'(sel_i) : TAP_W'(DEF_PHASE);
    end

endmodule

// File: rtl/serlp_tap_line.sv
module serlp_tap_line #(
    parameter int unsigned DEPTH = 14,
    parameter int unsigned TAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insert_i,
    input  logic [TAP_W-1:0] tap_i,
    output logic             pulse_o
);

    typedef struct packed {
        logic [DEPTH-1:0] line;
    } state_t;

    state_t           state_d, state_q;
    logic [DEPTH-1:0] stage_next;

    // Each slot takes the slot above it, or a freshly launched pulse.
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == DEPTH - 1) begin : g_top
            assign stage_next[i] = insert_i && (tap_i == TAP_W'(i));
        end else begin : g_mid
            assign stage_next[i] = (insert_i && (tap_i == TAP_W'(i)))
                                 || state_q.line[i+1];
        end
    end

    always_comb begin
        state_d      = state_q;
        state_d.line = stage_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pulse_o = state_q.line[0];

endmodule

// File: rtl/serlp_load_pulse_gen.sv
module serlp_load_pulse_gen #(
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned MIN_PHASE = 4,
    parameter int unsigned MAX_PHASE = 13,
    parameter int unsigned DEF_PHASE = 6
) (
    input  logic             clk_fast,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic [SEL_W-1:0] phase_sel_i,
    output logic             load_pulse_o,
    output logic             sel_err_o
);

    localparam int unsigned LINE_DEPTH = MAX_PHASE + 1;
    localparam int unsigned TAP_W      = $clog2(LINE_DEPTH);

    typedef struct packed {
        logic sel_err;
    } state_t;

    state_t           state_d, state_q;
    logic             rise;
    logic             illegal;
    logic [TAP_W-1:0] tap;

    serlp_edge_detect u_edge (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .rise_o (rise)
    );

    serlp_phase_decode #(
        .SEL_W     (SEL_W),
        .MIN_PHASE (MIN_PHASE),
        .MAX_PHASE (MAX_PHASE),
        .DEF_PHASE (DEF_PHASE),
        .TAP_W     (TAP_W)
    ) u_decode (
        .sel_i     (phase_sel_i),
        .tap_o     (tap),
        .illegal_o (illegal)
    );

    serlp_tap_line #(
        .DEPTH (LINE_DEPTH),
        .TAP_W (TAP_W)
    ) u_line (
        .clk      (clk_fast),
        .rst_n    (rst_n),
        .insert_i (rise),
        .tap_i    (tap),
        .pulse_o  (load_pulse_o)
    );

    always_comb begin
        state_d = state_q;
        if (rise) state_d.sel_err = illegal;
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign sel_err_o = state_q.sel_err;

endmodule

// File: rtl/serlp_load_pulse_chk.sv
module serlp_load_pulse_chk #(
    parameter int unsigned SEL_W     = 4,
    parameter int unsigned MIN_PHASE = 4,
    parameter int unsigned MAX_PHASE = 13
) (
    input logic             clk_fast,
    input logic             rst_n,
    input logic             sync_i,
    input logic [SEL_W-1:0] phase_sel_i,
    input logic             load_pulse_o,
    input logic             sel_err_o
);

    logic                 prev_c;
    logic                 rise_c;
    logic                 legal_c;
    logic [4:0]           pending_c;
    logic [MIN_PHASE-1:0] min_pipe_c;

    assign rise_c  = sync_i && !prev_c;
    assign legal_c = (32'(phase_sel_i) >= MIN_PHASE) && (32'(phase_sel_i) <= MAX_PHASE);

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            prev_c     <= 1'b0;
            pending_c  <= '0;
            min_pipe_c <= '0;
        end else begin
            prev_c <= sync_i;
            if (rise_c && !load_pulse_o && pending_c != 5'd31)
                pending_c <= pending_c + 5'd1;
            else if (!rise_c && load_pulse_o && pending_c != 5'd0)
                pending_c <= pending_c - 5'd1;
            min_pipe_c <= {min_pipe_c[MIN_PHASE-2:0],
                           rise_c && (32'(phase_sel_i) == MIN_PHASE)};
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk_fast)
        !rst_n |-> (!load_pulse_o && !sel_err_o));

    // R2
    min_phase_pos_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        min_pipe_c[MIN_PHASE-1] |=> load_pulse_o);

    // R3
    no_orphan_pulse_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        load_pulse_o |-> (pending_c != 5'd0));

    // R4
    illegal_flag_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (rise_c && !legal_c) |=> sel_err_o);

    // R4
    legal_clear_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (rise_c && legal_c) |=> !sel_err_o);

    // R5
    err_hold_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !rise_c |=> $stable(sel_err_o));

endmodule

bind serlp_load_pulse_gen serlp_load_pulse_chk #(
    .SEL_W     (SEL_W),
    .MIN_PHASE (MIN_PHASE),
    .MAX_PHASE (MAX_PHASE)
) u_chk (
    .clk_fast     (clk_fast),
    .rst_n        (rst_n),
    .sync_i       (sync_i),
    .phase_sel_i  (phase_sel_i),
    .load_pulse_o (load_pulse_o),
    .sel_err_o    (sel_err_o)
);

// File: tb/sim_serlp_load_pulse_gen.sv
module sim_serlp_load_pulse_gen;

    logic       clk_fast = 1'b0;
    logic       rst_n    = 1'b0;
    logic       sync_i   = 1'b0;
    logic [3:0] phase_sel_i = 4'd6;
    logic       load_pulse_o;
    logic       sel_err_o;

    int errs   = 0;
    int checks = 0;

    always #5 clk_fast = ~clk_fast;

    serlp_load_pulse_gen u0 (
        .clk_fast     (clk_fast),
        .rst_n        (rst_n),
        .sync_i       (sync_i),
        .phase_sel_i  (phase_sel_i),
        .load_pulse_o (load_pulse_o),
        .sel_err_o    (sel_err_o)
    );

    // {select code, expected delay, expected error flag}
    localparam logic [8:0] VEC [16] = '{
        {4'd0,  4'd6,  1'b1}, {4'd1,  4'd6,  1'b1},
        {4'd2,  4'd6,  1'b1}, {4'd3,  4'd6,  1'b1},
        {4'd4,  4'd4,  1'b0}, {4'd5,  4'd5,  1'b0},
        {4'd6,  4'd6,  1'b0}, {4'd7,  4'd7,  1'b0},
        {4'd8,  4'd8,  1'b0}, {4'd9,  4'd9,  1'b0},
        {4'd10, 4'd10, 1'b0}, {4'd11, 4'd11, 1'b0},
        {4'd12, 4'd12, 1'b0}, {4'd13, 4'd13, 1'b0},
        {4'd14, 4'd6,  1'b1}, {4'd15, 4'd6,  1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Launch a sync rise with code sel; returns pulse count and first index
    // counted in negedges after the sampling edge E0 (index k = after E0+k).
    task automatic launch(input logic [3:0] sel, output int hits, output int first,
                          output logic err0);
        hits  = 0;
        first = -1;
        @(negedge clk_fast);
        phase_sel_i = sel;
        sync_i      = 1'b1;
        @(posedge clk_fast);
        for (int k = 0; k < 24; k++) begin
            @(negedge clk_fast);
            if (k == 0) err0 = sel_err_o;
            if (k == 3) sync_i = 1'b0;
            if (load_pulse_o) begin
                hits++;
                if (first < 0) first = k;
            end
        end
    endtask

    initial begin
        int hits, first, second;
        logic err0;

        // R1: reset state
        repeat (3) @(posedge clk_fast);
        @(negedge clk_fast);
        chk(!load_pulse_o, "R1 load during reset", int'(load_pulse_o), 0);
        chk(!sel_err_o, "R1 err during reset", int'(sel_err_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk_fast);
        chk(!load_pulse_o && !sel_err_o, "R1 idle after reset",
            int'({load_pulse_o, sel_err_o}), 0);

        // R2 / R3 / R4: every select code
        for (int v = 0; v < 16; v++) begin
            logic [3:0] sel;
            int         dly;
            logic       eflag;
            sel   = VEC[v][8:5];
            dly   = int'(VEC[v][4:1]);
            eflag = VEC[v][0];
            launch(sel, hits, first, err0);
            chk(hits == 1, eflag ? "R4 single pulse" : "R3 single pulse", hits, 1);
            chk(first == dly, eflag ? "R4 fallback delay" : "R2 delay", first, dly);
            chk(err0 == eflag, "R4 error flag", int'(err0), int'(eflag));
        end

        // R5: flag holds between rises
        launch(4'd15, hits, first, err0);
        @(negedge clk_fast);
        phase_sel_i = 4'd6;
        repeat (4) @(negedge clk_fast);
        chk(sel_err_o == 1'b1, "R5 flag held", int'(sel_err_o), 1);
        launch(4'd6, hits, first, err0);
        chk(err0 == 1'b0, "R5 flag cleared at rise", int'(err0), 0);

        // R6: select change while pulse in flight
        hits = 0; first = -1;
        @(negedge clk_fast);
        phase_sel_i = 4'd12;
        sync_i      = 1'b1;
        @(posedge clk_fast);
        for (int k = 0; k < 24; k++) begin
            @(negedge clk_fast);
            if (k == 1) phase_sel_i = 4'd4;
            if (k == 3) sync_i = 1'b0;
            if (load_pulse_o) begin hits++; if (first < 0) first = k; end
        end
        chk(hits == 1, "R6 pulse count", hits, 1);
        chk(first == 12, "R6 delay kept", first, 12);

        // R7: overlapping long delay and next rise
        hits = 0; first = -1; second = -1;
        @(negedge clk_fast);
        phase_sel_i = 4'd13;
        sync_i      = 1'b1;
        @(posedge clk_fast);
        for (int k = 0; k < 28; k++) begin
            @(negedge clk_fast);
            if (k == 3) sync_i = 1'b0;
            if (k == 9) begin sync_i = 1'b1; phase_sel_i = 4'd5; end
            if (k == 12) sync_i = 1'b0;
            if (load_pulse_o) begin
                hits++;
                if (first < 0) first = k; else second = k;
            end
        end
        chk(hits == 2, "R7 pulse count", hits, 2);
        chk(first == 13, "R7 first pulse", first, 13);
        chk(second == 15, "R7 second pulse", second, 15);

        // R1: reset mid-flight discards pulse
        launch(4'd13, hits, first, err0);
        hits = 0;
        @(negedge clk_fast);
        phase_sel_i = 4'd13;
        sync_i      = 1'b1;
        @(posedge clk_fast);
        for (int k = 0; k < 24; k++) begin
            @(negedge clk_fast);
            if (k == 3) sync_i = 1'b0;
            if (k == 5) rst_n = 1'b0;
            if (k == 6) rst_n = 1'b1;
            if (load_pulse_o) hits++;
        end
        chk(hits == 0, "R1 in-flight pulse discarded", hits, 0);
        chk(!sel_err_o, "R1 flag after reset", int'(sel_err_o), 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_fast);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule